// File: doc/BRIEF.md
# Fully associative address translation buffer with lock-aware replacement

This block caches virtual-to-physical page translations in a small, fully associative table. Every entry carries a page-aligned virtual base, a partition tag, a context tag, a flag that marks a real (untranslated-space) mapping, and a 64-bit page descriptor. The descriptor holds the size code, the attribute bits and the physical base. A lookup port compares a request against all entries in the same cycle. It returns hit, the index of the matching entry, the translated physical address and the descriptor, so the consumer can judge the access rights.

A maintenance port takes one command per cycle. The commands are: insert with automatic victim choice, insert at a given index, drop one page, drop a context, drop a whole partition, and flush. Before an insert is written, every entry it would overlap is removed. An automatic victim is chosen from empty slots first. When none is empty, a rotating pointer picks the next slot that is not locked. A read port returns the tag image, the descriptor and the used flag of any slot by index. Each entry keeps a not-recently-used flag, and the flags are rearmed together once all of them are set.

Top module: `assoc_xlate_buf`

## Requirements
- R1: An entry hits when it is valid, its real flag and partition equal the request's, and the address lies inside its page. The context is compared only when the request is not real. Hit, index, physical address and descriptor are combinational in the request. The physical address is the descriptor's address bits above the page offset, joined with the request's page-offset bits.
- R2: Descriptor bits [2:0] are a size code. The page offset is 13+3*code bits wide: code 0 = 8K, 1 = 64K, 3 = 4M and 5 = 256M. Codes 6 and 7 are treated as 256M.
- R3: Descriptor bit 3 is lock, bit 4 privileged, bit 5 writable, bit 6 no-fault and bit 7 side-effect. Bits PA_W-1 down to the page offset hold the physical base. The descriptor of the hit entry is output unchanged.
- R4: An insert (op code 1 automatic, 2 at index) aligns the virtual address down to its page size. In the same update it removes every valid entry with the same real flag and partition whose page overlaps the new page. The context must also match unless the new entry is real.
- R5: An automatic insert takes the lowest-index empty slot, counting slots freed by the overlap removal.
- R6: With no empty slot, the victim is the first unlocked slot after the last round-robin victim, wrapping around. That slot becomes the new last victim.
- R7: With no empty slot and every slot locked, slot ENTRIES-1 is overwritten.
- R8: An insert or a non-probe lookup hit sets the entry's used flag. When this makes every flag set, all flags except that entry's are cleared. A probe lookup (lk_probe=1) leaves the flags unchanged. Removing an entry clears its flag.
- R9: Op code 3 removes the entry that the lookup rule (R1) matches against op_va, op_part, op_ctx and op_real. Op code 4 removes every entry whose partition and context both equal op_part and op_ctx.
- R10: Op code 5 removes only valid, unlocked entries of partition op_part. Locked entries and other partitions stay.
- R11: Op code 6 invalidates every entry.
- R12: The tag read returns all ones for an empty slot. Otherwise it returns partition in bits [63:61], the real flag in bit 60, the inverted size code in bits [58:56], the virtual base in [VA_W-1:13] and the context in [12:0]. The descriptor read returns all ones for an empty slot, and rd_used is 0 for it.
- R13: Commands take effect at the next rising edge. A lookup in the same cycle sees the old contents. A lookup hit in a cycle that carries a command does not update the used flags.
- R14: An insert at an index writes exactly that slot (op_index), whatever its lock bit, after the overlap removal of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 3 | Command: 0 none, 1 insert auto, 2 insert at index, 3 drop page, 4 drop context, 5 drop partition, 6 flush |
| op_va | input | VA_W | Command virtual address |
| op_part | input | PART_W | Command partition |
| op_ctx | input | CTX_W | Command context |
| op_real | input | 1 | Command real flag |
| op_pte | input | 64 | Descriptor to insert |
| op_index | input | IDX_W | Slot for insert at index |
| lk_valid | input | 1 | Lookup request present |
| lk_probe | input | 1 | Lookup is a probe (no used update) |
| lk_va | input | VA_W | Lookup virtual address |
| lk_part | input | PART_W | Lookup partition |
| lk_ctx | input | CTX_W | Lookup context |
| lk_real | input | 1 | Lookup real flag |
| lk_hit | output | 1 | Lookup hit |
| lk_index | output | IDX_W | Hit slot |
| lk_pa | output | PA_W | Translated physical address |
| lk_pte | output | 64 | Descriptor of hit entry |
| rd_index | input | IDX_W | Slot to read |
| rd_tag | output | 64 | Tag image of slot |
| rd_pte | output | 64 | Descriptor of slot |
| rd_used | output | 1 | Used flag of slot |

## Verification
A maintenance command and a lookup can arrive in the same cycle. The bench provokes this twice. First it issues an insert together with a lookup of the page being inserted, and expects a miss in that cycle and a hit one cycle later. Then it issues a flush together with a lookup of a resident page, and expects the hit from the old contents followed by a miss. The scoreboard queues each expectation for the cycle in which the registered table is visible, so a design that forwards commands into the lookup, or delays them by one more cycle, fails the comparison.

// File: rtl/axb_pkg.sv
// Shared definitions for the associative translation buffer.
// Assumes the descriptor layout given in the brief (size code in [2:0]).
package axb_pkg;
    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_INS_AUTO = 3'd1,
        OP_INS_AT   = 3'd2,
        OP_DMP_PAGE = 3'd3,
        OP_DMP_CTX  = 3'd4,
        OP_DMP_PART = 3'd5,
        OP_FLUSH    = 3'd6
    } axb_op_e;

    localparam int PTE_LOCK   = 3;
    localparam int MIN_SHIFT  = 13;
    localparam int SHIFT_STEP = 3;
    localparam int MAX_CODE   = 5;

    // Page-offset width for a size code, codes above MAX_CODE clamp.
    function automatic int pg_shift(input logic [2:0] code);
        logic [2:0] c;
        c = (code > 3'(MAX_CODE)) ? 3'(MAX_CODE) : code;
        return MIN_SHIFT + SHIFT_STEP * int'(c);
    endfunction

    // Page-offset mask for a size code, 64 bits wide.
    function automatic logic [63:0] pg_mask64(input logic [2:0] code);
        return (64'd1 << pg_shift(code)) - 64'd1;
    endfunction
endpackage

// File: rtl/axb_match.sv
// Parallel comparator array: for one query, flags each entry that holds the
// query address (hit_vec) and each entry whose page overlaps the query's
// page of size q_code (ovl_vec). Assumes stored bases are page aligned.
module axb_match #(
    parameter int N      = 16,
    parameter int VA_W   = 48,
    parameter int PART_W = 3,
    parameter int CTX_W  = 13
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N-1:0]                e_valid,
    input  logic [N-1:0]                e_real,
    input  logic [N-1:0][VA_W-1:0]      e_base,
    input  logic [N-1:0][2:0]           e_code,
    input  logic [N-1:0][PART_W-1:0]    e_part,
    input  logic [N-1:0][CTX_W-1:0]     e_ctx,
    input  logic [VA_W-1:0]             q_va,
    input  logic [2:0]                  q_code,
    input  logic [PART_W-1:0]           q_part,
    input  logic [CTX_W-1:0]            q_ctx,
    input  logic                        q_real,
    output logic [N-1:0]                hit_vec,
    output logic [N-1:0]                ovl_vec
);
    import axb_pkg::*;

    logic [VA_W-1:0] q_mask;
    logic [VA_W-1:0] q_base;

    // Query page mask and aligned base.
    assign q_mask = VA_W'(pg_mask64(q_code));
    assign q_base = q_va & ~q_mask;

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic            key;
        logic [VA_W-1:0] emask;
        // Entry page mask.
        assign emask = VA_W'(pg_mask64(e_code[g]));
        // Identity match: real flag, partition, context when not real.
        assign key = e_valid[g] && (e_real[g] == q_real) && (e_part[g] == q_part)
                     && (q_real || (e_ctx[g] == q_ctx));
        // Address inside entry page.
        assign hit_vec[g] = key && ((q_va & ~emask) == e_base[g]);
        // Aligned power-of-two pages overlap iff one holds the other's base.
        assign ovl_vec[g] = key && (((q_base & ~emask) == e_base[g]) ||
                                    ((e_base[g] & ~q_mask) == q_base));
    end

    // R1: overlap removal keeps at most one entry matching any query.
    a_r1_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/axb_victim.sv
// Victim selector: lowest empty slot, else the first unlocked slot after
// rr_last (wrapping), else slot N-1. pick_rr marks the rotating case.
module axb_victim #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     free_vec,
    input  logic [N-1:0]     lock_vec,
    input  logic [IDX_W-1:0] rr_last,
    output logic [IDX_W-1:0] pick,
    output logic             pick_rr
);
    // Priority search over empty slots, then rotating search over unlocked.
    always_comb begin
        logic found;
        found   = 1'b0;
        pick    = IDX_W'(N - 1);
        pick_rr = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!found && free_vec[i]) begin
                pick  = IDX_W'(i);
                found = 1'b1;
            end
        end
        for (int k = 1; k <= N; k++) begin
            if (!found && !lock_vec[(int'(rr_last) + k) % N]) begin
                pick    = IDX_W'((int'(rr_last) + k) % N);
                pick_rr = 1'b1;
                found   = 1'b1;
            end
        end
    end

    // R5: an empty slot is always preferred.
    a_r5_free_first: assert property (@(posedge clk) disable iff (!rst_n)
        (|free_vec) |-> free_vec[pick]);
    // R6: the rotating choice never lands on a locked slot.
    a_r6_skip_locked: assert property (@(posedge clk) disable iff (!rst_n)
        pick_rr |-> !lock_vec[pick]);
    // R7: full and fully locked falls back to the last slot.
    a_r7_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|free_vec) && (&lock_vec)) |-> (pick == IDX_W'(N - 1)));
endmodule

// File: rtl/assoc_xlate_buf.sv
// Fully associative translation buffer. Holds ENTRIES translations, looks
// up combinationally, applies one maintenance command per clock and keeps
// not-recently-used flags. Assumes PART_W <= 3, CTX_W <= 13, VA_W <= 56,
// PA_W <= VA_W and ENTRIES >= 2.
module assoc_xlate_buf #(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 48,
    parameter int PA_W    = 40,
    parameter int PART_W  = 3,
    parameter int CTX_W   = 13,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_code,
    input  logic [VA_W-1:0]   op_va,
    input  logic [PART_W-1:0] op_part,
    input  logic [CTX_W-1:0]  op_ctx,
    input  logic              op_real,
    input  logic [63:0]       op_pte,
    input  logic [IDX_W-1:0]  op_index,
    input  logic              lk_valid,
    input  logic              lk_probe,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [PART_W-1:0] lk_part,
    input  logic [CTX_W-1:0]  lk_ctx,
    input  logic              lk_real,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_index,
    output logic [PA_W-1:0]   lk_pa,
    output logic [63:0]       lk_pte,
    input  logic [IDX_W-1:0]  rd_index,
    output logic [63:0]       rd_tag,
    output logic [63:0]       rd_pte,
    output logic              rd_used
);
    import axb_pkg::*;

    localparam int  N     = ENTRIES;
    localparam bit  EXACT = ((1 << IDX_W) == ENTRIES);

    logic [N-1:0]              valid_q, used_q, real_q;
    logic [N-1:0][VA_W-1:0]    base_q;
    logic [N-1:0][PART_W-1:0]  part_q;
    logic [N-1:0][CTX_W-1:0]   ctx_q;
    logic [N-1:0][63:0]        pte_q;
    logic [IDX_W-1:0]          rr_q;

    logic [N-1:0][2:0]         code_w;
    logic [N-1:0]              lock_w, ctx_sel, part_sel;
    logic [N-1:0]              lk_vec, lk_ovl_unused, op_hit, op_ovl;
    logic [N-1:0]              v_n, u_n;
    logic [IDX_W-1:0]          vic_idx, at_idx, wr_idx;
    logic                      vic_rr, wr_en, rr_upd;
    axb_op_e                   op_e;

    assign op_e = axb_op_e'(op_code);

    // Per-entry size code, lock bit and bulk-removal selects.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            code_w[i]   = pte_q[i][2:0];
            lock_w[i]   = pte_q[i][PTE_LOCK];
            ctx_sel[i]  = (part_q[i] == op_part) && (ctx_q[i] == op_ctx);
            part_sel[i] = valid_q[i] && !lock_w[i] && (part_q[i] == op_part);
        end
    end

    axb_match #(.N(N), .VA_W(VA_W), .PART_W(PART_W), .CTX_W(CTX_W)) u_lk_match (
        .clk(clk), .rst_n(rst_n),
        .e_valid(valid_q), .e_real(real_q), .e_base(base_q), .e_code(code_w),
        .e_part(part_q), .e_ctx(ctx_q),
        .q_va(lk_va), .q_code(3'd0), .q_part(lk_part), .q_ctx(lk_ctx), .q_real(lk_real),
        .hit_vec(lk_vec), .ovl_vec(lk_ovl_unused)
    );

    axb_match #(.N(N), .VA_W(VA_W), .PART_W(PART_W), .CTX_W(CTX_W)) u_op_match (
        .clk(clk), .rst_n(rst_n),
        .e_valid(valid_q), .e_real(real_q), .e_base(base_q), .e_code(code_w),
        .e_part(part_q), .e_ctx(ctx_q),
        .q_va(op_va), .q_code(op_pte[2:0]), .q_part(op_part), .q_ctx(op_ctx),
        .q_real(op_real),
        .hit_vec(op_hit), .ovl_vec(op_ovl)
    );

    axb_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
        .clk(clk), .rst_n(rst_n),
        .free_vec(~(valid_q & ~op_ovl)), .lock_vec(lock_w), .rr_last(rr_q),
        .pick(vic_idx), .pick_rr(vic_rr)
    );

    // Lookup result: lowest hitting slot, translated address and descriptor.
    always_comb begin
        logic [PA_W-1:0] m;
        lk_hit   = |lk_vec;
        lk_index = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (lk_vec[i]) lk_index = IDX_W'(i);
        end
        m      = PA_W'(pg_mask64(code_w[lk_index]));
        lk_pte = lk_hit ? pte_q[lk_index] : 64'd0;
        lk_pa  = lk_hit ? ((pte_q[lk_index][PA_W-1:0] & ~m) | (lk_va[PA_W-1:0] & m))
                        : '0;
    end

    // Indexed read: tag image, descriptor, used flag.
    always_comb begin
        logic [2:0] inv;
        inv     = ~code_w[rd_index];
        rd_used = used_q[rd_index];
        if (valid_q[rd_index]) begin
            rd_tag = 64'(ctx_q[rd_index]) | 64'(base_q[rd_index])
                   | (64'(part_q[rd_index]) << 61) | (64'(real_q[rd_index]) << 60)
                   | (64'(inv) << 56);
            rd_pte = pte_q[rd_index];
        end else begin
            rd_tag = '1;
            rd_pte = '1;
        end
    end

    // Slot for insert at index, clamped when ENTRIES is not a power of two.
    always_comb begin
        at_idx = op_index;
        if (!EXACT && int'(op_index) >= N) at_idx = IDX_W'(N - 1);
    end

    // Next valid/used flags, write slot and pointer update for this cycle.
    always_comb begin
        v_n    = valid_q;
        u_n    = used_q;
        wr_en  = 1'b0;
        wr_idx = vic_idx;
        rr_upd = 1'b0;
        case (op_e)
            OP_INS_AUTO, OP_INS_AT: begin
                v_n   = valid_q & ~op_ovl;
                u_n   = used_q & ~op_ovl;
                wr_en = 1'b1;
                if (op_e == OP_INS_AT) begin
                    wr_idx = at_idx;
                end else begin
                    rr_upd = vic_rr;
                end
                v_n[wr_idx] = 1'b1;
                u_n[wr_idx] = 1'b1;
                if (&u_n) begin
                    u_n         = '0;
                    u_n[wr_idx] = 1'b1;
                end
            end
            OP_DMP_PAGE: begin
                v_n = valid_q & ~op_hit;
                u_n = used_q & ~op_hit;
            end
            OP_DMP_CTX: begin
                v_n = valid_q & ~ctx_sel;
                u_n = used_q & ~ctx_sel;
            end
            OP_DMP_PART: begin
                v_n = valid_q & ~part_sel;
                u_n = used_q & ~part_sel;
            end
            OP_FLUSH: begin
                v_n = '0;
                u_n = '0;
            end
            default: begin
                if (lk_valid && !lk_probe && lk_hit) begin
                    u_n[lk_index] = 1'b1;
                    if (&u_n) begin
                        u_n           = '0;
                        u_n[lk_index] = 1'b1;
                    end
                end
            end
        endcase
    end

    // Table state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            used_q  <= '0;
            real_q  <= '0;
            base_q  <= '0;
            part_q  <= '0;
            ctx_q   <= '0;
            pte_q   <= '0;
            rr_q    <= '0;
        end else begin
            valid_q <= v_n;
            used_q  <= u_n;
            if (rr_upd) rr_q <= wr_idx;
            if (wr_en) begin
                base_q[wr_idx] <= op_va & ~VA_W'(pg_mask64(op_pte[2:0]));
                part_q[wr_idx] <= op_part;
                ctx_q[wr_idx]  <= op_ctx;
                real_q[wr_idx] <= op_real;
                pte_q[wr_idx]  <= op_pte;
            end
        end
    end

    // R11: flush leaves no valid entry.
    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_FLUSH) |=> (valid_q == '0));
    // R8: the used flags are never all set after an update.
    a_r8_used_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        !(&used_q));
    // R8: only valid entries carry a used flag.
    a_r8_used_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (used_q & ~valid_q) == '0);
    // R8: a probe lookup in an idle cycle keeps the flags.
    a_r8_probe_keeps_used: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_NONE && lk_valid && lk_probe) |=> $stable(used_q));
    // R10: dropping a partition never removes a locked entry.
    a_r10_locked_survive: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_DMP_PART) |=> (($past(valid_q) & $past(lock_w) & ~valid_q) == '0));
endmodule

// File: tb/assoc_xlate_buf_test.sv
// Scoreboard bench: driver tasks queue expected output values, a monitor
// compares them shortly after each falling edge.
module assoc_xlate_buf_test;
    localparam int N = 16, VA_W = 48, PA_W = 40, PART_W = 3, CTX_W = 13, IDX_W = 4;
    localparam logic [2:0] C_NONE = 3'd0, C_AUTO = 3'd1, C_AT = 3'd2, C_PAGE = 3'd3,
                           C_CTX = 3'd4, C_PART = 3'd5, C_FLUSH = 3'd6;
    localparam int S_HIT = 0, S_IDX = 1, S_PA = 2, S_PTE = 3, S_TAG = 4, S_RPTE = 5, S_USED = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] op_code = C_NONE;
    logic [VA_W-1:0] op_va = '0;
    logic [PART_W-1:0] op_part = '0;
    logic [CTX_W-1:0] op_ctx = '0;
    logic op_real = 1'b0;
    logic [63:0] op_pte = '0;
    logic [IDX_W-1:0] op_index = '0;
    logic lk_valid = 1'b0, lk_probe = 1'b1, lk_real = 1'b0;
    logic [VA_W-1:0] lk_va = '0;
    logic [PART_W-1:0] lk_part = '0;
    logic [CTX_W-1:0] lk_ctx = '0;
    logic lk_hit, rd_used;
    logic [IDX_W-1:0] lk_index, rd_index = '0;
    logic [PA_W-1:0] lk_pa;
    logic [63:0] lk_pte, rd_tag, rd_pte;

    assoc_xlate_buf #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W), .PART_W(PART_W),
                      .CTX_W(CTX_W)) uut (.*);

    always #5 clk = ~clk;

    typedef struct { int sel; logic [63:0] exp; string req; } item_t;
    item_t sb[$];
    int n_checks = 0, n_fail = 0;
    bit done = 0;

    function automatic logic [63:0] observe(input int sel);
        case (sel)
            S_HIT:   return 64'(lk_hit);
            S_IDX:   return 64'(lk_index);
            S_PA:    return 64'(lk_pa);
            S_PTE:   return lk_pte;
            S_TAG:   return rd_tag;
            S_RPTE:  return rd_pte;
            default: return 64'(rd_used);
        endcase
    endfunction

    // Monitor: compare every queued expectation 3 ns after the falling edge.
    initial forever begin
        @(negedge clk);
        #3;
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_checks++;
            if (observe(it.sel) !== it.exp) begin
                n_fail++;
                $display("FAIL %s: output %0d actual %h expected %h", it.req, it.sel,
                         observe(it.sel), it.exp);
            end
        end
    end

    task automatic push(input int sel, input logic [63:0] exp, input string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    // R2 page offset mask from size code.
    function automatic logic [63:0] pmask(input logic [2:0] code);
        int c;
        c = (int'(code) > 5) ? 5 : int'(code);
        return (64'd1 << (13 + 3 * c)) - 64'd1;
    endfunction

    function automatic logic [63:0] exp_tag(input logic [2:0] part, input logic rl,
            input logic [2:0] code, input logic [47:0] va, input logic [12:0] ctx);
        logic [2:0] inv;
        inv = ~code;
        return (64'(part) << 61) | (64'(rl) << 60) | (64'(inv) << 56)
             | (64'(va) & ~pmask(code)) | 64'(ctx);
    endfunction

    function automatic logic [63:0] exp_pa(input logic [63:0] pte, input logic [47:0] va);
        logic [63:0] m;
        m = pmask(pte[2:0]);
        return ((pte & ~m) | (64'(va) & m)) & ((64'd1 << PA_W) - 64'd1);
    endfunction

    task automatic do_op(input logic [2:0] c, input logic [47:0] va, input logic [2:0] part,
            input logic [12:0] ctx, input logic rl, input logic [63:0] pte, input int idx);
        op_code = c; op_va = va; op_part = part; op_ctx = ctx; op_real = rl;
        op_pte = pte; op_index = IDX_W'(idx);
        @(negedge clk);
        op_code = C_NONE;
    endtask

    task automatic look(input logic [47:0] va, input logic [2:0] part, input logic [12:0] ctx,
            input logic rl, input logic probe, input logic hit, input int idx,
            input logic [63:0] pte, input string req);
        lk_valid = 1'b1; lk_va = va; lk_part = part; lk_ctx = ctx; lk_real = rl;
        lk_probe = probe;
        #1;
        push(S_HIT, 64'(hit), req);
        if (hit) begin
            push(S_IDX, 64'(idx), req);
            push(S_PA, exp_pa(pte, va), req);
            push(S_PTE, pte, req);
        end
        @(negedge clk);
        lk_valid = 1'b0; lk_probe = 1'b1;
    endtask

    task automatic rd(input int idx, input logic vld, input logic [63:0] tag,
            input logic [63:0] pte, input logic used, input string req);
        rd_index = IDX_W'(idx);
        #1;
        push(S_TAG, vld ? tag : '1, req);
        push(S_RPTE, vld ? pte : '1, req);
        push(S_USED, 64'(vld & used), req);
        @(negedge clk);
    endtask

    function automatic logic [47:0] vf(input int i);
        return 48'h0000_1000_0000 + 48'(i) * 48'h2000;
    endfunction
    function automatic logic [63:0] df(input int i, input logic lk);
        return (64'h0000_0001_0000_0000 + 64'(i) * 64'h2000) | (64'(lk) << 3);
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    localparam logic [47:0] VA0 = 48'h1234_5678_9ABC, VA1 = 48'h0000_4000_0000,
                            VA2 = 48'h1234_5655_5555, VAA = 48'h0000_2000_0000,
                            VAB = 48'h0000_2000_2000, VAC = 48'h0000_3000_0000,
                            VAD = 48'h0000_3000_2000, VAE = 48'h0000_3000_4000,
                            VAF = 48'h0000_5000_0000, VAH = 48'h0000_6000_0000,
                            VAK = 48'h0000_7123_4567;
    localparam logic [63:0] D0 = 64'h0000_0012_3456_0020, D1 = 64'h0000_0000_8000_0001,
                            D2 = 64'h0000_0055_0000_0003, DA = 64'h0000_0077_0000_0000,
                            DB = 64'h0000_0078_0000_0000, DC = 64'h0000_0079_0000_0008,
                            DD = 64'h0000_007A_0000_0008, DE = 64'h0000_007B_0000_0000,
                            DF2 = 64'h0000_007C_0000_0000, DG = 64'h0000_007D_0000_0000,
                            DH = 64'h0000_0011_0000_0000, DK = 64'h0000_0010_0000_0007;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state: empty table (R12), no hit (R1).
        rd(0, 0, '0, '0, 0, "R12 reset read");
        look(VA0, 1, 5, 0, 1, 0, 0, '0, "R1 reset miss");

        // R1/R3: basic insert and lookup, key fields.
        do_op(C_AUTO, VA0, 1, 5, 0, D0, 0);
        look(VA0, 1, 5, 0, 1, 1, 0, D0, "R1 R3 hit with descriptor");
        look(VA0, 1, 6, 0, 1, 0, 0, '0, "R1 context mismatch");
        look(VA0, 1, 5, 1, 1, 0, 0, '0, "R1 real mismatch");
        look(VA0, 2, 5, 0, 1, 0, 0, '0, "R1 partition mismatch");
        rd(0, 1, exp_tag(1, 0, 0, VA0, 5), D0, 1, "R12 tag image");

        // R1/R2: real entry ignores context, 64K range.
        do_op(C_AUTO, VA1, 1, 9, 1, D1, 0);
        look(48'h0000_4000_ABCD, 1, 3, 1, 1, 1, 1, D1, "R1 R2 real hit 64K");
        look(48'h0000_4001_0000, 1, 3, 1, 1, 0, 0, '0, "R2 outside 64K");

        // R4: 4M insert overlaps slot 0, which is removed and reused (R5).
        do_op(C_AUTO, VA2, 1, 5, 0, D2, 0);
        rd(0, 1, exp_tag(1, 0, 3, VA2, 5), D2, 1, "R4 aligned overlapping insert");
        look(VA0, 1, 5, 0, 1, 1, 0, D2, "R4 old page now served by 4M");
        rd(1, 1, exp_tag(1, 1, 1, VA1, 9), D1, 1, "R4 real entry untouched");
        rd(2, 0, '0, '0, 0, "R5 slot 2 still empty");

        // R9: drop a real page.
        do_op(C_PAGE, 48'h0000_4000_1234, 1, 0, 1, '0, 0);
        rd(1, 0, '0, '0, 0, "R9 page dropped");
        look(VA1, 1, 0, 1, 1, 0, 0, '0, "R9 page no longer hits");

        // R5/R8: fill slots 1..15, slot 5 unlocked.
        for (int i = 1; i < N; i++) begin
            do_op(C_AUTO, vf(i), 1, 5, 0, df(i, i != 5), 0);
        end
        rd(3, 1, exp_tag(1, 0, 0, vf(3), 5), df(3, 1), 0, "R8 flags rearmed");
        rd(15, 1, exp_tag(1, 0, 0, vf(15), 5), df(15, 1), 1, "R8 newest keeps flag");
        rd(0, 1, exp_tag(1, 0, 3, VA2, 5), D2, 0, "R8 old flag cleared");
        look(vf(3) + 48'h10, 1, 5, 0, 1, 1, 3, df(3, 1), "R8 probe lookup");
        rd(3, 1, exp_tag(1, 0, 0, vf(3), 5), df(3, 1), 0, "R8 probe leaves flag");
        look(vf(3), 1, 5, 0, 0, 1, 3, df(3, 1), "R8 real lookup");
        rd(3, 1, exp_tag(1, 0, 0, vf(3), 5), df(3, 1), 1, "R8 lookup sets flag");

        // R6: rotating victim skips locked slots, then wraps.
        do_op(C_AUTO, VAA, 1, 5, 0, DA, 0);
        rd(5, 1, exp_tag(1, 0, 0, VAA, 5), DA, 1, "R6 first unlocked after pointer");
        do_op(C_AUTO, VAB, 1, 5, 0, DB, 0);
        rd(0, 1, exp_tag(1, 0, 0, VAB, 5), DB, 1, "R6 wrap to slot 0");

        // R14/R7: lock everything by index, then auto insert hits slot N-1.
        do_op(C_AT, VAC, 1, 5, 0, DC, 0);
        do_op(C_AT, VAD, 1, 5, 0, DD, 5);
        rd(5, 1, exp_tag(1, 0, 0, VAD, 5), DD, 1, "R14 insert at index");
        do_op(C_AUTO, VAE, 1, 5, 0, DE, 0);
        rd(15, 1, exp_tag(1, 0, 0, VAE, 5), DE, 1, "R7 all locked uses last slot");
        rd(14, 1, exp_tag(1, 0, 0, vf(14), 5), df(14, 1), 0, "R7 neighbour kept");

        // R10: partition drop spares locked entries and other partitions.
        do_op(C_AT, VAF, 1, 5, 0, DF2, 7);
        do_op(C_AT, VAF, 2, 5, 0, DG, 8);
        do_op(C_PART, '0, 1, 0, 0, '0, 0);
        rd(7, 0, '0, '0, 0, "R10 unlocked removed");
        rd(15, 0, '0, '0, 0, "R10 unlocked last slot removed");
        rd(9, 1, exp_tag(1, 0, 0, vf(9), 5), df(9, 1), 0, "R10 locked kept");
        rd(8, 1, exp_tag(2, 0, 0, VAF, 5), DG, 1, "R10 other partition kept");

        // R9: context drop removes locked entries of that context too.
        do_op(C_CTX, '0, 1, 5, 0, '0, 0);
        rd(9, 0, '0, '0, 0, "R9 context dropped");
        rd(8, 1, exp_tag(2, 0, 0, VAF, 5), DG, 1, "R9 other partition kept");

        // R13: insert and lookup of the same page in one cycle.
        op_code = C_AUTO; op_va = VAH; op_part = 2; op_ctx = 7; op_real = 0; op_pte = DH;
        lk_valid = 1'b1; lk_va = VAH; lk_part = 2; lk_ctx = 7; lk_real = 0; lk_probe = 1'b1;
        #1;
        push(S_HIT, 64'd0, "R13 lookup sees old table");
        @(negedge clk);
        op_code = C_NONE;
        #1;
        push(S_HIT, 64'd1, "R13 insert visible next cycle");
        push(S_IDX, 64'd0, "R13 R5 lowest free slot");
        @(negedge clk);

        // R11/R13: flush with a simultaneous lookup.
        op_code = C_FLUSH;
        #1;
        push(S_HIT, 64'd1, "R13 flush cycle still hits");
        @(negedge clk);
        op_code = C_NONE;
        #1;
        push(S_HIT, 64'd0, "R11 flushed");
        @(negedge clk);
        lk_valid = 1'b0;
        rd(8, 0, '0, '0, 0, "R11 all slots empty");

        // R2: code 7 behaves as 256M.
        do_op(C_AUTO, VAK, 0, 0, 0, DK, 0);
        look(48'h0000_7ABC_DEF0, 0, 0, 0, 1, 1, 0, DK, "R2 clamped 256M");
        rd(0, 1, exp_tag(0, 0, 7, VAK, 0), DK, 1, "R2 R12 tag inverted code");

        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule